// File: doc/BRIEF.md
# Multi-mode 8-bit timer counter

This block is an 8-bit counter that moves one step on each prescaled tick. A base tick enable arrives from the clock tree. An internal power-of-two prescaler, chosen by a 3-bit code, thins it into the active ticks that move the count. A 2-bit mode input selects one of four counting patterns: free-running up count, one-shot down count, up count with a programmable period, and symmetric up/down count between zero and the period.

A level run input lets the count advance, and dropping it freezes the count where it stands. In down mode, each rising edge of run loads the period value. A clear strobe zeroes the count, the prescaler and the up/down direction. Each mode has its own terminal-count event, which sets a sticky overflow flag. The flag holds until a flag-clear pulse, and an enable gates it onto the interrupt request.

Top module: `tmr8_multimode`

## Requirements
- R1: While run is 1, the count moves once for every 2^n cycles with tick_en high, where n is div_sel (0 to 7). The prescaler's position is reset by clr, and cycles with tick_en low do not advance it.
- R2: With run at 0 and clr at 0, the count holds its value on every clock, and neither resets nor reloads.
- R3: With mode 00 (free-running), the count rises by one per active tick and wraps from 0xFF to 0x00. The flag is set on the tick that makes the count 0xFF.
- R4: With mode 01 (down), a rising edge of run loads period into the count on that clock. Each active tick then decrements the count, and the tick that reaches 0x00 sets the flag. After that the count holds at 0x00 until run rises again or clr is pulsed.
- R5: With mode 10 (modulo), an active tick with the count equal to period returns it to 0x00 without setting the flag. Otherwise the tick increments the count.
- R6: With mode 10 and the count above period, the count keeps rising. The tick that makes it 0xFF sets the flag, and the next tick wraps it to 0x00.
- R7: With mode 11 (up/down), the count rises from 0x00 to period and then falls back to 0x00, repeating. The flag is set on each tick that brings the count down to 0x00.
- R8: clr zeroes the count on the next clock, sets the up/down direction to up and resets the prescaler. It takes priority over loading and counting, and it leaves the flag unchanged.
- R9: The flag stays set until flag_clr is pulsed. If flag_clr and a terminal event occur on the same clock, the flag ends up set.
- R10: irq is high exactly when the flag is set and irq_en is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_en | input | 1 | Base tick enable |
| div_sel | input | 3 | Prescaler code n, ratio 2^n |
| mode | input | 2 | 00 free, 01 down, 10 modulo, 11 up/down |
| run | input | 1 | Count enable level; rising edge reloads in down mode |
| clr | input | 1 | Clear strobe |
| period | input | 8 | Period / reload value |
| irq_en | input | 1 | Interrupt enable |
| flag_clr | input | 1 | Overflow flag clear pulse |
| count | output | 8 | Live count value |
| ovf_flag | output | 1 | Sticky overflow flag |
| irq | output | 1 | Interrupt request |

## Verification
Because the count is visible on every clock, a bad next-state value shows up at the port one clock after the tick that computes it. A lost or stale up/down direction shows as a wrong step right after a turn or a clear, and a prescaler phase error shows as an advance one or more base ticks early or late. A flag event raised in the wrong place appears on ovf_flag and irq in the same clock as the count that caused it, and then persists, so even an isolated error stays visible until flag_clr.

// File: rtl/tmr8_pkg.sv
package tmr8_pkg;
   typedef enum logic [1:0] {
      TM_FREE = 2'b00,
      TM_DOWN = 2'b01,
      TM_MOD  = 2'b10,
      TM_UPDN = 2'b11
   } tmode_e;
endpackage

// File: rtl/tmr8_prescale.sv
module tmr8_prescale #(
   parameter int SELW = 3
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            clr,
   input  logic            run,
   input  logic            tick_en,
   input  logic [SELW-1:0] sel,
   output logic            adv
);
   localparam int PCW = (1 << SELW) - 1;

   generate
      if (SELW == 0) begin : g_direct
         assign adv = run & tick_en;
      end else begin : g_divide
         logic [PCW-1:0] pre_cnt;
         logic [PCW-1:0] mask;

         always_comb mask = ~({PCW{1'b1}} << sel);

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                pre_cnt <= '0;
            else if (clr)              pre_cnt <= '0;
            else if (run && tick_en)   pre_cnt <= pre_cnt + 1'b1;
         end

         assign adv = run && tick_en && ((pre_cnt & mask) == mask);
      end
   endgenerate
endmodule

// File: rtl/tmr8_step.sv
module tmr8_step
   import tmr8_pkg::*;
#(
   parameter int W = 8
) (
   input  tmode_e       mode,
   input  logic [W-1:0] cnt,
   input  logic [W-1:0] period,
   input  logic         dir_up,
   output logic [W-1:0] nxt,
   output logic         nxt_dir_up,
   output logic         hit
);
   localparam logic [W-1:0] MAXV = '1;
   localparam logic [W-1:0] ONE  = W'(1);

   always_comb begin
      nxt        = cnt;
      nxt_dir_up = dir_up;
      hit        = 1'b0;
      unique case (mode)
         TM_FREE: begin
            nxt = cnt + ONE;
            hit = (cnt == MAXV - ONE);
         end
         TM_DOWN: begin
            if (cnt != '0) begin
               nxt = cnt - ONE;
               hit = (cnt == ONE);
            end
         end
         TM_MOD: begin
            if (cnt == period) begin
               nxt = '0;
            end else begin
               nxt = cnt + ONE;
               hit = (cnt == MAXV - ONE) && (cnt > period);
            end
         end
         TM_UPDN: begin
            if (dir_up && (cnt < period)) begin
               nxt = cnt + ONE;
            end else if (cnt == '0) begin
               nxt        = '0;
               hit        = 1'b1;
               nxt_dir_up = 1'b1;
            end else begin
               nxt        = cnt - ONE;
               hit        = (cnt == ONE);
               nxt_dir_up = (cnt == ONE);
            end
         end
      endcase
   end
endmodule

// File: rtl/tmr8_flag.sv
module tmr8_flag (
   input  logic clk,
   input  logic rst_n,
   input  logic hit,
   input  logic flag_clr,
   input  logic irq_en,
   output logic flag,
   output logic irq
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        flag <= 1'b0;
      else if (hit)      flag <= 1'b1;
      else if (flag_clr) flag <= 1'b0;
   end

   assign irq = flag & irq_en;

   a_r9_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      flag && !flag_clr |=> flag);
   a_r9_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
      hit |=> flag);
endmodule

// File: rtl/tmr8_multimode.sv
module tmr8_multimode
   import tmr8_pkg::*;
#(
   parameter int W    = 8,
   parameter int SELW = 3
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            tick_en,
   input  logic [SELW-1:0] div_sel,
   input  logic [1:0]      mode,
   input  logic            run,
   input  logic            clr,
   input  logic [W-1:0]    period,
   input  logic            irq_en,
   input  logic            flag_clr,
   output logic [W-1:0]    count,
   output logic            ovf_flag,
   output logic            irq
);
   localparam logic [W-1:0] MAXV = '1;

   generate
      if (W < 2) begin : g_bad_width
         $error("tmr8_multimode: W must be at least 2");
      end
      if (SELW > 5) begin : g_bad_sel
         $error("tmr8_multimode: SELW above 5 makes an oversized prescaler");
      end
   endgenerate

   tmode_e       mode_e;
   logic         run_q;
   logic         dir_up;
   logic         adv;
   logic         load;
   logic [W-1:0] nxt;
   logic         nxt_dir_up;
   logic         step_hit;
   logic         hit;

   assign mode_e = tmode_e'(mode);
   assign load   = (mode_e == TM_DOWN) && run && !run_q;

   tmr8_prescale #(.SELW(SELW)) u_pre (
      .clk     (clk),
      .rst_n   (rst_n),
      .clr     (clr),
      .run     (run),
      .tick_en (tick_en),
      .sel     (div_sel),
      .adv     (adv)
   );

   tmr8_step #(.W(W)) u_step (
      .mode       (mode_e),
      .cnt        (count),
      .period     (period),
      .dir_up     (dir_up),
      .nxt        (nxt),
      .nxt_dir_up (nxt_dir_up),
      .hit        (step_hit)
   );

   assign hit = adv && !clr && !load && step_hit;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         count  <= '0;
         dir_up <= 1'b1;
         run_q  <= 1'b0;
      end else begin
         run_q <= run;
         if (clr) begin
            count  <= '0;
            dir_up <= 1'b1;
         end else if (load) begin
            count  <= period;
         end else if (adv) begin
            count  <= nxt;
            dir_up <= nxt_dir_up;
         end
      end
   end

   tmr8_flag u_flag (
      .clk      (clk),
      .rst_n    (rst_n),
      .hit      (hit),
      .flag_clr (flag_clr),
      .irq_en   (irq_en),
      .flag     (ovf_flag),
      .irq      (irq)
   );

   a_r2_freeze: assert property (@(posedge clk) disable iff (!rst_n)
      !run && !clr |=> $stable(count));
   a_r8_clear: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> (count == '0) && dir_up);
   a_r3_free_flag_at_max: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ovf_flag) && ($past(mode) == TM_FREE) |-> count == MAXV);
   a_r4_down_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_e == TM_DOWN) && (count == '0) && run_q && !clr |=> count == '0);
   a_r5_mod_wrap: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_e == TM_MOD) && (count == period) && adv && !clr |=> count == '0);
endmodule

// File: tb/sim_tmr8_multimode.sv
module sim_tmr8_multimode;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       tick_en = 1'b0;
   logic [2:0] div_sel = '0;
   logic [1:0] mode = '0;
   logic       run = 1'b0;
   logic       clr = 1'b0;
   logic [7:0] period = '0;
   logic       irq_en = 1'b0;
   logic       flag_clr = 1'b0;
   logic [7:0] count;
   logic       ovf_flag;
   logic       irq;

   int n_chk = 0;
   int n_fail = 0;
   bit finished = 1'b0;

   typedef struct {
      logic [7:0] c;
      logic       f;
      string      tag;
   } exp_t;
   exp_t q[$];

   always #5 clk = ~clk;

   tmr8_multimode u0 (
      .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .div_sel(div_sel),
      .mode(mode), .run(run), .clr(clr), .period(period), .irq_en(irq_en),
      .flag_clr(flag_clr), .count(count), .ovf_flag(ovf_flag), .irq(irq)
   );

   task automatic check(input bit ok, input string tag, input string what,
                        input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
      end
   endtask

   task automatic cyc(input logic [7:0] c, input logic f, input string tag);
      exp_t e;
      @(posedge clk);
      #1;
      e.c = c; e.f = f; e.tag = tag;
      q.push_back(e);
   endtask

   task automatic finish_run();
      if (!finished) begin
         finished = 1'b1;
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   endtask

   // monitor: pops one expectation per clock and compares at the falling edge
   always @(negedge clk) begin
      exp_t e;
      if (q.size() != 0) begin
         e = q.pop_front();
         check(count == e.c, e.tag, "count", count, e.c);
         check(ovf_flag == e.f, e.tag, "flag", ovf_flag, e.f);
         check(irq == (e.f & irq_en), "R10", "irq", irq, e.f & irq_en);
      end
   end

   initial begin
      repeat (200000) @(posedge clk);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      repeat (3) @(posedge clk);
      #1;
      check(count == 8'h00, "RST", "count", count, 0);
      check(ovf_flag == 1'b0, "RST", "flag", ovf_flag, 0);
      check(irq == 1'b0, "RST", "irq", irq, 0);
      rst_n = 1'b1;
      cyc(8'h00, 0, "RST");

      // R3 free-running
      tick_en = 1; run = 1; mode = 2'b00;
      for (int k = 1; k < 255; k++) cyc(8'(k), 0, "R3");
      cyc(8'hFF, 1, "R3");
      cyc(8'h00, 1, "R3");
      irq_en = 1;
      cyc(8'h01, 1, "R10");
      flag_clr = 1;
      cyc(8'h02, 0, "R9");
      flag_clr = 0;

      // R2 freeze
      run = 0;
      for (int k = 0; k < 5; k++) cyc(8'h02, 0, "R2");
      clr = 1;
      cyc(8'h00, 0, "R8");
      clr = 0;

      // R1 prescaler divide by 4
      div_sel = 3'd2; run = 1;
      cyc(8'h00, 0, "R1"); cyc(8'h00, 0, "R1"); cyc(8'h00, 0, "R1");
      cyc(8'h01, 0, "R1"); cyc(8'h01, 0, "R1"); cyc(8'h01, 0, "R1");
      cyc(8'h01, 0, "R1"); cyc(8'h02, 0, "R1");
      tick_en = 0;
      for (int k = 0; k < 3; k++) cyc(8'h02, 0, "R1");
      tick_en = 1;
      cyc(8'h02, 0, "R1"); cyc(8'h02, 0, "R1"); cyc(8'h02, 0, "R1");
      cyc(8'h03, 0, "R1");

      // R1 divide by 128 after clear resets prescaler
      run = 0; clr = 1;
      cyc(8'h00, 0, "R8");
      clr = 0; div_sel = 3'd7; run = 1;
      for (int k = 0; k < 127; k++) cyc(8'h00, 0, "R1");
      cyc(8'h01, 0, "R1");
      run = 0; div_sel = 3'd0;
      cyc(8'h01, 0, "R2");

      // R4 down mode
      mode = 2'b01; period = 8'd5; clr = 1;
      cyc(8'h00, 0, "R8");
      clr = 0; run = 1;
      cyc(8'h05, 0, "R4");
      cyc(8'h04, 0, "R4"); cyc(8'h03, 0, "R4");
      cyc(8'h02, 0, "R4"); cyc(8'h01, 0, "R4");
      cyc(8'h00, 1, "R4");
      for (int k = 0; k < 3; k++) cyc(8'h00, 1, "R4");
      run = 0;
      cyc(8'h00, 1, "R4");
      run = 1;
      cyc(8'h05, 1, "R4");
      flag_clr = 1;
      cyc(8'h04, 0, "R9");
      flag_clr = 0;
      cyc(8'h03, 0, "R4"); cyc(8'h02, 0, "R4"); cyc(8'h01, 0, "R4");
      flag_clr = 1;
      cyc(8'h00, 1, "R9");
      flag_clr = 0;

      // R5 modulo
      run = 0; mode = 2'b10; period = 8'd3; clr = 1; flag_clr = 1;
      cyc(8'h00, 0, "R8");
      clr = 0; flag_clr = 0; run = 1;
      for (int r = 0; r < 2; r++) begin
         cyc(8'h01, 0, "R5"); cyc(8'h02, 0, "R5");
         cyc(8'h03, 0, "R5"); cyc(8'h00, 0, "R5");
      end

      // R6 modulo with count above period
      run = 0; mode = 2'b01; period = 8'hFD;
      cyc(8'h00, 0, "R2");
      run = 1;
      cyc(8'hFD, 0, "R4");
      mode = 2'b10; period = 8'h10;
      cyc(8'hFE, 0, "R6");
      cyc(8'hFF, 1, "R6");
      cyc(8'h00, 1, "R6");
      cyc(8'h01, 1, "R6");

      // R7 up/down, R8 direction reset
      run = 0; mode = 2'b11; period = 8'd3; clr = 1; flag_clr = 1;
      cyc(8'h00, 0, "R8");
      clr = 0; flag_clr = 0; run = 1;
      cyc(8'h01, 0, "R7"); cyc(8'h02, 0, "R7"); cyc(8'h03, 0, "R7");
      cyc(8'h02, 0, "R7"); cyc(8'h01, 0, "R7"); cyc(8'h00, 1, "R7");
      cyc(8'h01, 1, "R7"); cyc(8'h02, 1, "R7"); cyc(8'h03, 1, "R7");
      cyc(8'h02, 1, "R7");
      clr = 1;
      cyc(8'h00, 1, "R8");
      clr = 0;
      cyc(8'h01, 1, "R8"); cyc(8'h02, 1, "R8");
      cyc(8'h03, 1, "R7"); cyc(8'h02, 1, "R7");

      run = 0;
      wait (q.size() == 0);
      @(posedge clk);
      #1;
      finish_run();
   end
endmodule